// File: doc/BRIEF.md
# Hotplug Slot Event Register Block

This block keeps track of insertion and removal events for a bank of hot-pluggable slots. It raises one event interrupt toward firmware whenever a new event becomes pending. Firmware reads two pending masks over a simple register bus, one for insertions and one for removals. It acknowledges what it has read by writing the same mask to a separate clear register. Because of this, an event that arrives between the read and the acknowledge survives. When firmware has finished a removal, it writes the eject register, and the block then disables the slot and pulses its power-off line.

A platform hotplug request enables its slot at once. An unplug request only records that a removal is wanted, and the slot stays enabled until it is ejected. The block also accepts a system reset request. On that request it sweeps every slot whose removal is still pending and ejects them one per clock, starting from the lowest index. It then drops all pending insertions. During the sweep a busy flag is high and bus writes are ignored. The hard reset `rstN` returns the block to an empty state.

Top module: `hotplug_event_regs`

## Requirements
- R1: The word index is the byte address divided by 4. Reads return data on `busRdData` one cycle after `busRdEn`. The words are: 0 pending-insert mask, 1 pending-remove mask, 2 eject (reads 0), 3 removable mask (reads `removableMask`), 4 clear-insert (reads 0), 5 clear-remove (reads 0), 6 event status with the event flag in bit 1. Every other word reads 0. Bit n of each mask belongs to slot n.
- R2: The event flag and `eventIrq` become 1 in the cycle after any pending-insert or pending-remove bit goes from 0 to 1. They stay 1 until a write to word 6 with bit 1 set. If such a write coincides with a new rise, the flag stays set.
- R3: A `plugReq` bit sets that slot's `slotEn` bit and pending-insert bit on the next cycle. It leaves the bits of other slots unchanged.
- R4: An `unplugReq` bit sets only that slot's pending-remove bit. `slotEn` never falls except through an eject.
- R5: A write to word 4 clears the written bits in pending-insert, and a write to word 5 clears the written bits in pending-remove. Neither changes `slotEn`. A hardware request to the same bit in the same cycle wins over the clear.
- R6: A nonzero write to word 2 acts only on its lowest set bit, slot k. It clears pending-remove bit k. If `removableMask[k]` is 1, it also clears `slotEn[k]` and drives `ejectPulse` with only bit k set for one cycle. If `removableMask[k]` is 0, there is no pulse and no enable change. A write of zero does nothing.
- R7: A write to word 0 or word 1 overwrites the whole mask. A write to word 3 has no effect.
- R8: After `sysResetReq`, `sweepBusy` rises on the next cycle. Each busy cycle ejects the lowest pending-remove slot under the R6 rules. The first busy cycle that finds no pending removal clears pending-insert and ends the sweep, so busy lasts one cycle more than the number of pending removals.
- R9: Bus writes made while `sweepBusy` is 1 have no effect. `sysResetReq` during a sweep is ignored.
- R10: While `rstN` is low, both masks, `slotEn`, `ejectPulse`, `eventIrq` and `sweepBusy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| busAddr | input | ADDR_W | Byte address of the register word |
| busWrData | input | DATA_W | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | DATA_W | Read data, valid the cycle after the read strobe |
| plugReq | input | NUM_SLOTS | Per-slot insertion request pulses |
| unplugReq | input | NUM_SLOTS | Per-slot removal request pulses |
| removableMask | input | NUM_SLOTS | Constant mask of slots that may be ejected |
| sysResetReq | input | 1 | Pulse that starts the reset-time removal sweep |
| eventIrq | output | 1 | Event interrupt to firmware |
| ejectPulse | output | NUM_SLOTS | One-cycle power-off pulse per ejected slot |
| slotEn | output | NUM_SLOTS | Per-slot enable status |
| sweepBusy | output | 1 | High while the reset sweep runs |

## Verification
The bench targets the race where a slot is unplugged and a different slot is plugged before firmware acknowledges. A design that zeroed both masks on each new event would lose that removal, and the slot would never be ejected. It drives a clear and a hardware set to the same bit in the same cycle, and an event-flag clear together with a new rise; a design that let the clear win would drop the event. It ejects with several bits written and on a non-removable slot; a design that acted on every bit, or ignored the removable mask, would show extra pulses or disabled slots. It runs sweeps with several pending removals and writes arriving during the sweep; a wrong order, a missing final clear of pending-insert, or writes that leak through would all show in the pulse sequence and the later reads.

// File: rtl/hpe_pkg.sv
package hpe_pkg;

  // Word indices of the register map (byte address / 4)
  localparam int W_PEND_UP   = 0;
  localparam int W_PEND_DOWN = 1;
  localparam int W_EJECT     = 2;
  localparam int W_REMOVABLE = 3;
  localparam int W_CLR_UP    = 4;
  localparam int W_CLR_DOWN  = 5;
  localparam int W_EVT_STS   = 6;

  // Bit of the event status word that carries the slot event flag
  localparam int STS_BIT = 1;

  typedef enum logic {
    ST_IDLE,
    ST_SWEEP
  } sweepState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       wrUp;
    logic       wrDown;
    logic       clrUp;
    logic       clrDown;
    logic       ejectWr;
    logic       clrSts;
    logic       sweepEject;
    logic       sweepClrUp;
    logic       rdEn;
    logic [2:0] rdSel;
  } hpeStrobes_t;

endpackage

// File: rtl/hpe_ctrl.sv
module hpe_ctrl
  import hpe_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              sysResetReq,
  input  logic              downAny,
  output hpeStrobes_t       stb,
  output logic              busy
);

  localparam int SEL_W = ADDR_W - 2;

  sweepState_t state, stateNext;
  logic [SEL_W-1:0] wordSel;
  int unsigned      wordIdx;
  logic             wrOk;

  assign wordSel = busAddr[ADDR_W-1:2];
  assign wordIdx = 32'(wordSel);
  assign busy    = (state == ST_SWEEP);
  assign wrOk    = busWrEn && !busy;

  always_comb begin
    stb         = '0;
    stateNext   = state;
    stb.wrUp    = wrOk && (wordIdx == W_PEND_UP);
    stb.wrDown  = wrOk && (wordIdx == W_PEND_DOWN);
    stb.ejectWr = wrOk && (wordIdx == W_EJECT);
    stb.clrUp   = wrOk && (wordIdx == W_CLR_UP);
    stb.clrDown = wrOk && (wordIdx == W_CLR_DOWN);
    stb.clrSts  = wrOk && (wordIdx == W_EVT_STS);
    stb.rdEn    = busRdEn;
    stb.rdSel   = (wordIdx < 8) ? wordSel[2:0] : 3'd7;
    unique case (state)
      ST_IDLE: begin
        if (sysResetReq) stateNext = ST_SWEEP;
      end
      ST_SWEEP: begin
        if (downAny) begin
          stb.sweepEject = 1'b1;
        end else begin
          stb.sweepClrUp = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/hpe_datapath.sv
module hpe_datapath
  import hpe_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hpeStrobes_t          stb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_SLOTS-1:0] plugReq,
  input  logic [NUM_SLOTS-1:0] unplugReq,
  input  logic [NUM_SLOTS-1:0] removableMask,
  output logic [NUM_SLOTS-1:0] pendUp,
  output logic [NUM_SLOTS-1:0] pendDown,
  output logic [NUM_SLOTS-1:0] slotEn,
  output logic [NUM_SLOTS-1:0] ejectPulse,
  output logic                 irq,
  output logic [DATA_W-1:0]    rdData,
  output logic                 downAny
);

  logic [NUM_SLOTS-1:0] slotMask;
  logic [NUM_SLOTS-1:0] ejMask;
  logic [NUM_SLOTS-1:0] upNext, downNext, enNext, riseV;
  logic                 stsFlag;
  logic [DATA_W-1:0]    rdMux;

  function automatic logic [NUM_SLOTS-1:0] lowestBit(input logic [NUM_SLOTS-1:0] v);
    return v & (~v + NUM_SLOTS'(1));
  endfunction

  assign slotMask = wrData[NUM_SLOTS-1:0];
  assign downAny  = |pendDown;
  assign ejMask   = stb.sweepEject ? lowestBit(pendDown) :
                    stb.ejectWr    ? lowestBit(slotMask) : '0;

  // Per-slot next state: hardware requests are OR-ed in last so they win
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign upNext[s] = ((stb.wrUp ? slotMask[s] : pendUp[s])
                        & ~(stb.clrUp & slotMask[s])
                        & ~stb.sweepClrUp) | plugReq[s];
    assign downNext[s] = ((stb.wrDown ? slotMask[s] : pendDown[s])
                          & ~(stb.clrDown & slotMask[s])
                          & ~ejMask[s]) | unplugReq[s];
    assign enNext[s] = (slotEn[s] & ~(ejMask[s] & removableMask[s])) | plugReq[s];
    assign riseV[s]  = (upNext[s] & ~pendUp[s]) | (downNext[s] & ~pendDown[s]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendUp     <= '0;
      pendDown   <= '0;
      slotEn     <= '0;
      ejectPulse <= '0;
    end else begin
      pendUp     <= upNext;
      pendDown   <= downNext;
      slotEn     <= enNext;
      ejectPulse <= ejMask & removableMask;
    end
  end

  // Event flag: a new rise outranks a write-1-to-clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                stsFlag <= 1'b0;
    else if (|riseV)                          stsFlag <= 1'b1;
    else if (stb.clrSts && wrData[STS_BIT])   stsFlag <= 1'b0;
  end

  assign irq = stsFlag;

  always_comb begin
    rdMux = '0;
    unique case (stb.rdSel)
      3'(W_PEND_UP):   rdMux = DATA_W'(pendUp);
      3'(W_PEND_DOWN): rdMux = DATA_W'(pendDown);
      3'(W_REMOVABLE): rdMux = DATA_W'(removableMask);
      3'(W_EVT_STS):   rdMux[STS_BIT] = stsFlag;
      default:         rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdMux;
  end

endmodule

// File: rtl/hotplug_event_regs.sv
module hotplug_event_regs
  import hpe_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_SLOTS-1:0] plugReq,
  input  logic [NUM_SLOTS-1:0] unplugReq,
  input  logic [NUM_SLOTS-1:0] removableMask,
  input  logic                 sysResetReq,
  output logic                 eventIrq,
  output logic [NUM_SLOTS-1:0] ejectPulse,
  output logic [NUM_SLOTS-1:0] slotEn,
  output logic                 sweepBusy
);

  hpeStrobes_t          stb;
  logic                 downAny;
  logic [NUM_SLOTS-1:0] pendUp, pendDown;

  hpe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .sysResetReq(sysResetReq),
    .downAny    (downAny),
    .stb        (stb),
    .busy       (sweepBusy)
  );

  hpe_datapath #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (busWrData),
    .plugReq      (plugReq),
    .unplugReq    (unplugReq),
    .removableMask(removableMask),
    .pendUp       (pendUp),
    .pendDown     (pendDown),
    .slotEn       (slotEn),
    .ejectPulse   (ejectPulse),
    .irq          (eventIrq),
    .rdData       (busRdData),
    .downAny      (downAny)
  );

endmodule

// File: rtl/hpe_checker.sv
module hpe_checker #(
  parameter int NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SLOTS-1:0] plugReq,
  input logic [NUM_SLOTS-1:0] unplugReq,
  input logic [NUM_SLOTS-1:0] removableMask,
  input logic [NUM_SLOTS-1:0] pendUp,
  input logic [NUM_SLOTS-1:0] pendDown,
  input logic [NUM_SLOTS-1:0] slotEn,
  input logic [NUM_SLOTS-1:0] ejectPulse,
  input logic                 eventIrq,
  input logic                 sweepBusy
);

  p_plug_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (plugReq != '0) |=> (((pendUp & slotEn) & $past(plugReq)) == $past(plugReq)));

  p_unplug_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (unplugReq != '0) |=> ((pendDown & $past(unplugReq)) == $past(unplugReq)));

  // R4 and R6: an enable bit only falls together with its eject pulse
  p_en_falls_on_eject_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((~slotEn & $past(slotEn) & ~ejectPulse) == '0));

  p_irq_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (((pendUp & ~$past(pendUp)) | (pendDown & ~$past(pendDown))) != '0) |-> eventIrq);

  p_eject_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ejectPulse));

  p_eject_removable_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((ejectPulse & ~removableMask) == '0));

  p_sweep_ends_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sweepBusy) && ($past(plugReq) == '0) && ($past(unplugReq) == '0))
      |-> ((pendUp == '0) && (pendDown == '0)));

endmodule

bind hotplug_event_regs hpe_checker #(.NUM_SLOTS(NUM_SLOTS)) u_hpeChecker (
  .clk          (clk),
  .rstN         (rstN),
  .plugReq      (plugReq),
  .unplugReq    (unplugReq),
  .removableMask(removableMask),
  .pendUp       (pendUp),
  .pendDown     (pendDown),
  .slotEn       (slotEn),
  .ejectPulse   (ejectPulse),
  .eventIrq     (eventIrq),
  .sweepBusy    (sweepBusy)
);

// File: tb/hotplug_event_regs_bench.sv
module hotplug_event_regs_bench;

  localparam logic [31:0] REM = 32'h0FF0_F0FB;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [31:0] plugReq = '0, unplugReq = '0;
  logic        sysResetReq = 1'b0;
  logic        eventIrq, sweepBusy;
  logic [31:0] ejectPulse, slotEn;

  int nVec = 0, nFail = 0, cyc = 0;
  bit done = 0;

  // Bench model of the programmer-visible state
  logic [31:0] mUp = '0, mDown = '0, mEn = '0, mEj = '0;
  logic        mSts = 0, mBusy = 0;

  always #5 clk = ~clk;

  hotplug_event_regs u_hotplug_event_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
    .plugReq(plugReq), .unplugReq(unplugReq), .removableMask(REM),
    .sysResetReq(sysResetReq), .eventIrq(eventIrq), .ejectPulse(ejectPulse),
    .slotEn(slotEn), .sweepBusy(sweepBusy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 32'h1 << i;
    return '0;
  endfunction

  function automatic logic [31:0] expRead(input logic [2:0] w);
    case (w)
      3'd0: return mUp;
      3'd1: return mDown;
      3'd3: return REM;
      3'd6: return {30'b0, mSts, 1'b0};
      default: return '0;
    endcase
  endfunction

  // One clock: drive, update model from the requirements, compare
  task automatic step(input logic [31:0] plug, input logic [31:0] unplug,
                      input logic wr, input logic rd, input logic [2:0] word,
                      input logic [31:0] data, input logic sysReq);
    logic [31:0] up, dn, en, ej, rdExp;
    logic        wrOk, sweepEj, sweepClr, sts, busyN;
    @(negedge clk);
    plugReq = plug; unplugReq = unplug; busWrEn = wr; busRdEn = rd;
    busAddr = {word, 2'b00}; busWrData = data; sysResetReq = sysReq;
    @(posedge clk);
    wrOk     = wr && !mBusy;
    sweepEj  = mBusy && (mDown != 0);
    sweepClr = mBusy && (mDown == 0);
    rdExp    = expRead(word);
    ej = sweepEj ? lowest(mDown) : ((wrOk && word == 3'd2) ? lowest(data) : '0);
    up = (wrOk && word == 3'd0) ? data : mUp;
    if (wrOk && word == 3'd4) up &= ~data;
    if (sweepClr) up = '0;
    up |= plug;
    dn = (wrOk && word == 3'd1) ? data : mDown;
    if (wrOk && word == 3'd5) dn &= ~data;
    dn = (dn & ~ej) | unplug;
    en = (mEn & ~(ej & REM)) | plug;
    sts = mSts;
    if (wrOk && word == 3'd6 && data[1]) sts = 1'b0;
    if (((up & ~mUp) | (dn & ~mDown)) != 0) sts = 1'b1;
    busyN = mBusy ? !sweepClr : sysReq;
    mUp = up; mDown = dn; mEn = en; mEj = ej & REM; mSts = sts; mBusy = busyN;
    #1;
    chk("R3/R4/R6 slotEn", slotEn, mEn);
    chk("R6/R8 ejectPulse", ejectPulse, mEj);
    chk("R2 eventIrq", {31'b0, eventIrq}, {31'b0, mSts});
    chk("R8/R9 sweepBusy", {31'b0, sweepBusy}, {31'b0, mBusy});
    if (rd) chk("R1/R5/R7 busRdData", busRdData, rdExp);
  endtask

  task automatic idle();
    step('0, '0, 0, 0, 3'd0, '0, 0);
  endtask
  task automatic wrW(input logic [2:0] w, input logic [31:0] d);
    step('0, '0, 1, 0, w, d, 0);
  endtask
  task automatic rdW(input logic [2:0] w);
    step('0, '0, 0, 1, w, '0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R10: outputs empty while reset is held
    chk("R10 slotEn", slotEn, '0);
    chk("R10 eventIrq", {31'b0, eventIrq}, '0);
    chk("R10 sweepBusy", {31'b0, sweepBusy}, '0);
    chk("R10 ejectPulse", ejectPulse, '0);
    @(negedge clk); rstN = 1'b1;
    // R1: map readback after reset
    for (int w = 0; w < 8; w++) rdW(3'(w));

    // R3/R2: plug slot 3, then acknowledge the event flag
    step(32'h8, '0, 0, 0, 3'd0, '0, 0);
    rdW(3'd0); rdW(3'd6);
    wrW(3'd6, 32'h2); rdW(3'd6);
    // R4 race: unplug 3, plug 5 before firmware acknowledges
    step('0, 32'h8, 0, 0, 3'd0, '0, 0);
    step(32'h20, '0, 0, 0, 3'd0, '0, 0);
    rdW(3'd1); rdW(3'd0);
    // R5: acknowledge only slot 3 in pending-insert
    wrW(3'd4, 32'h8); rdW(3'd0);
    // R5: plug slot 7 while clearing slot 7 in the same cycle, set wins
    step(32'h80, '0, 1, 0, 3'd4, 32'h80, 0); rdW(3'd0);
    // R2: new rise coincident with a flag clear keeps the flag
    wrW(3'd6, 32'h2);
    step(32'h100, '0, 1, 0, 3'd6, 32'h2, 0); rdW(3'd6);
    // R6: eject with two bits written acts on slot 3 only
    wrW(3'd2, 32'h28); idle(); rdW(3'd1);
    // R6: non-removable slot 2 keeps its enable
    step(32'h4, 32'h4, 0, 0, 3'd0, '0, 0);
    wrW(3'd2, 32'h4); idle(); rdW(3'd1);
    wrW(3'd2, 32'h0); idle();
    // R7: removable is read-only, pending masks are overwritable
    wrW(3'd3, 32'h0); rdW(3'd3);
    wrW(3'd0, 32'hA5); rdW(3'd0);
    wrW(3'd1, 32'h0); rdW(3'd1);
    // R8/R9: sweep of slots 0,1,4 with writes arriving during it
    step(32'h13, 32'h13, 0, 0, 3'd0, '0, 0);
    step('0, '0, 0, 0, 3'd0, '0, 1);
    wrW(3'd5, 32'hFFFF_FFFF);
    wrW(3'd0, 32'hFFFF_FFFF);
    step('0, '0, 0, 1, 3'd1, '0, 1);
    repeat (3) idle();
    rdW(3'd0); rdW(3'd1);

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] pl, up, d;
      logic [2:0]  w;
      int          op;
      pl = ($urandom % 6 == 0) ? (32'h1 << ($urandom % 32)) : '0;
      up = ($urandom % 6 == 0) ? (32'h1 << ($urandom % 32)) : '0;
      op = $urandom % 10;
      w  = 3'($urandom % 8);
      d  = $urandom;
      case (op)
        0, 1, 2: step(pl, up, 0, 0, 3'd0, '0, ($urandom % 64) == 0);
        3, 4:    step(pl, up, 0, 1, w, '0, 0);
        5:       step(pl, up, 1, 0, 3'd4, ($urandom % 2) ? mUp : d, 0);
        6:       step(pl, up, 1, 0, 3'd5, ($urandom % 2) ? mDown : d, 0);
        7:       step(pl, up, 1, 0, 3'd2, ($urandom % 2) ? (32'h1 << ($urandom % 32)) : d, 0);
        8:       step(pl, up, 1, 0, 3'd6, 32'h2, 0);
        default: step(pl, up, 1, 0, ($urandom % 2) ? 3'd3 : 3'($urandom % 2), d, 0);
      endcase
    end
    repeat (40) idle();
    for (int w = 0; w < 8; w++) rdW(3'(w));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule